// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between an asynchronous, microprocessor-style bus and a word-wide flash array. The host drives active-low chip enable, output enable and write enable, plus a reset/power-down input and a write-protect input. All of these are sampled on the block clock. Commands written over the bus are decoded here. A write never goes straight into the array: it picks what later reads return (array contents, identifier codes or the status byte), or it starts a timed word program or block erase.

The controller also covers the quiet states. With chip enable or output enable inactive, the data bus is released; a running operation keeps going to its end. Holding the power-down input low long enough enters deep power-down, which halts everything and aborts any running operation. On return, the controller goes back to array reads with a clean status. The array is a behavioural register memory, and operation time is counted in clock cycles.

The data bus is split into a value `dq_o` and an enable `dq_oe_o`. An enable of zero stands for high impedance, and `dq_o` is then zero.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After rst_ni is released, reads return array data, every array word reads 0xFFFF, and a read-status command shows 0x0080.
- R2: dq_oe_o is 1 only when ce_ni and oe_ni are both low, rp_ni is high and deep power-down is not active. In every other case dq_oe_o is 0 and dq_o is 0.
- R3: A write is active while ce_ni and we_ni are both sampled low. addr_i and data_i from the last active cycle are captured. The command acts at the clock edge where either enable is first sampled high, provided rp_ni is high then. Bus values presented after that edge are ignored.
- R4: Commands are decoded from data bits 7:0 at any address, with bits 15:8 ignored: 0xFF selects array reads, 0x90 identifier reads and 0x70 status reads. Unknown codes are ignored. No command write alters the array.
- R5: In identifier mode, address 0 reads MFR_CODE, address 1 reads DEV_CODE and every other address reads 0.
- R6: Writing 0x40 or 0x10 and then a second write with address and data starts a program. After PROG_CYC cycles, the word holds its old value ANDed with the data.
- R7: Writing 0x20 and then 0xD0 at any address in a block (upper ADDR_W-BLK_W address bits) sets every word of that block to 0xFFFF after ERASE_CYC cycles. A second write other than 0xD0 sets status bits 5 and 4 and erases nothing.
- R8: Status bit 7 is 0 while an operation runs and 1 otherwise. While an operation runs, every read returns status. Commands written during an operation are ignored. After a setup or start, the mode is status reads.
- R9: While wp_ni is low, a program or erase aimed at a block whose LOCK_MASK bit is set is rejected. Rejection sets status bit 1, plus bit 4 for a program or bit 5 for an erase, and leaves the array unchanged.
- R10: Command 0x50 clears status bits 5, 4 and 1 and does not change the read mode.
- R11: With ce_ni high, a running operation still completes on time.
- R12: rp_ni sampled low for RP_MIN consecutive cycles enters deep power-down. A shorter low pulse changes neither the mode nor a running operation. On the first high sample after power-down, the controller enters array mode, drops any pending setup and clears status to 0x80.
- R13: Entering deep power-down during an operation ends it. The target word (program) or every word of the target block (erase) then reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling and operation clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| rp_ni | input | 1 | Reset / deep power-down, active low |
| wp_ni | input | 1 | Write protect, active low |
| addr_i | input | ADDR_W | Word address |
| data_i | input | DATA_W | Write data / command |
| dq_o | output | DATA_W | Read data, 0 when not driven |
| dq_oe_o | output | 1 | Data bus drive enable (0 = high impedance) |

## Verification
A wrong mode or a stale pending setup shows up on the first read after the offending write, because the source of `dq_o` changes in the same cycle. A wrong operation counter shows up as a status bit 7 that goes high one cycle early or late. Corrupt array words stay hidden until a read-array command and a read of the affected address, so the bench reads back every touched word and its block neighbours. Power-down faults appear only after the wake edge, as a leftover identifier mode or status error bits.

// File: rtl/fcui_pkg.sv
package fcui_pkg;
  typedef enum logic [1:0] {RD_ARRAY = 2'd0, RD_ID = 2'd1, RD_STAT = 2'd2} rd_mode_e;
  typedef enum logic [1:0] {SEQ_IDLE = 2'd0, SEQ_ERASE = 2'd1, SEQ_PROG = 2'd2} seq_e;
  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_PROG = 2'd1, OP_ERASE = 2'd2} op_e;

  localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_RD_ID    = 8'h90;
  localparam logic [7:0] CMD_RD_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLR_STAT = 8'h50;
  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
  localparam logic [7:0] CMD_PROG     = 8'h40;
  localparam logic [7:0] CMD_PROG_ALT = 8'h10;

  localparam int ST_ERASE_ERR = 5;
  localparam int ST_PROG_ERR  = 4;
  localparam int ST_LOCK_ERR  = 1;
endpackage

// File: rtl/fcui_bus_capture.sv
module fcui_bus_capture #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              rp_ni,
  input  logic              pd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic wr_now, wr_q;

  assign wr_now = ~ce_ni & ~we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      wr_q <= wr_now;
      if (wr_now) begin
        addr_o <= addr_i;
        data_o <= data_i;
      end
    end
  end

  // first enable to rise ends the write; captured values are from the last active cycle
  assign commit_o = wr_q & ~wr_now & rp_ni & ~pd_i;
endmodule

// File: rtl/fcui_pd_ctrl.sv
module fcui_pd_ctrl #(
  parameter int RP_MIN = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rp_ni,
  output logic pd_o,
  output logic enter_o,
  output logic wake_o
);
  localparam int CW = $clog2(RP_MIN + 1);

  logic [CW-1:0] cnt_q;
  logic          pd_q;

  assign enter_o = ~rp_ni & ~pd_q & (cnt_q == CW'(RP_MIN - 1));
  assign wake_o  = rp_ni & pd_q;
  assign pd_o    = pd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pd_q  <= 1'b0;
    end else begin
      if (rp_ni)                     cnt_q <= '0;
      else if (cnt_q != CW'(RP_MIN)) cnt_q <= cnt_q + 1'b1;
      pd_q <= enter_o | (pd_q & ~rp_ni);
    end
  end
endmodule

// File: rtl/fcui_array.sv
module fcui_array import fcui_pkg::*; #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int BLK_W     = 5,
  parameter int PROG_CYC  = 24,
  parameter int ERASE_CYC = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_prog_i,
  input  logic              start_erase_i,
  input  logic              abort_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic [DATA_W-1:0] op_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o
);
  localparam int WORDS  = 1 << ADDR_W;
  localparam int BIDX_W = ADDR_W - BLK_W;
  localparam int MAXC   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW     = $clog2(MAXC + 1);

  logic [DATA_W-1:0] mem_q [WORDS];
  op_e               op_q;
  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              apply;

  assign busy_o    = (op_q != OP_NONE);
  assign apply     = busy_o & (abort_i | (cnt_q == '0));
  assign rd_data_o = mem_q[rd_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_NONE;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (busy_o) begin
      if (apply) op_q  <= OP_NONE;
      else       cnt_q <= cnt_q - 1'b1;
    end else if (start_prog_i) begin
      op_q   <= OP_PROG;
      cnt_q  <= CW'(PROG_CYC - 1);
      addr_q <= op_addr_i;
      data_q <= op_data_i;
    end else if (start_erase_i) begin
      op_q   <= OP_ERASE;
      cnt_q  <= CW'(ERASE_CYC - 1);
      addr_q <= op_addr_i;
      data_q <= op_data_i;
    end
  end

  // abort leaves the target invalid (all zero); program can only clear bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
    end else if (apply) begin
      for (int i = 0; i < WORDS; i++) begin
        if (op_q == OP_PROG && ADDR_W'(i) == addr_q)
          mem_q[i] <= abort_i ? '0 : (mem_q[i] & data_q);
        else if (op_q == OP_ERASE && BIDX_W'(i >> BLK_W) == addr_q[ADDR_W-1:BLK_W])
          mem_q[i] <= abort_i ? '0 : '1;
      end
    end
  end

  p_abort_ends_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i && busy_o |=> !busy_o);

  p_start_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_prog_i || start_erase_i) |-> !busy_o);
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl import fcui_pkg::*; #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int BLK_W     = 5,
  parameter int PROG_CYC  = 24,
  parameter int ERASE_CYC = 48,
  parameter int RP_MIN    = 13,
  parameter logic [(1<<(ADDR_W-BLK_W))-1:0] LOCK_MASK = 'h80,
  parameter logic [DATA_W-1:0] MFR_CODE = 'h005A,
  parameter logic [DATA_W-1:0] DEV_CODE = 'h00C3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              rp_ni,
  input  logic              wp_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic              pd, pd_enter, pd_wake, commit, busy;
  logic              locked, accept, start_prog, start_erase;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data, arr_rd, rd_val, status_w;
  logic [7:0]        cmd;
  rd_mode_e          mode_q;
  seq_e              seq_q;
  logic [6:0]        stat_q;

  fcui_pd_ctrl #(.RP_MIN(RP_MIN)) u_pd (
    .clk_i(clk_i), .rst_ni(rst_ni), .rp_ni(rp_ni),
    .pd_o(pd), .enter_o(pd_enter), .wake_o(pd_wake)
  );

  fcui_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .we_ni(we_ni),
    .rp_ni(rp_ni), .pd_i(pd), .addr_i(addr_i), .data_i(data_i),
    .commit_o(commit), .addr_o(cap_addr), .data_o(cap_data)
  );

  fcui_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_arr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_prog_i(start_prog), .start_erase_i(start_erase), .abort_i(pd_enter),
    .op_addr_i(cap_addr), .op_data_i(cap_data), .rd_addr_i(addr_i),
    .rd_data_o(arr_rd), .busy_o(busy)
  );

  assign cmd         = cap_data[7:0];
  assign accept      = commit & ~busy;
  assign locked      = ~wp_ni & LOCK_MASK[cap_addr[ADDR_W-1:BLK_W]];
  assign start_prog  = accept & (seq_q == SEQ_PROG) & ~locked;
  assign start_erase = accept & (seq_q == SEQ_ERASE) & (cmd == CMD_CONFIRM) & ~locked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= RD_ARRAY;
      seq_q  <= SEQ_IDLE;
      stat_q <= '0;
    end else if (pd_wake) begin
      mode_q <= RD_ARRAY;
      seq_q  <= SEQ_IDLE;
      stat_q <= '0;
    end else if (accept) begin
      unique case (seq_q)
        SEQ_PROG: begin
          seq_q  <= SEQ_IDLE;
          mode_q <= RD_STAT;
          if (locked) begin
            stat_q[ST_PROG_ERR] <= 1'b1;
            stat_q[ST_LOCK_ERR] <= 1'b1;
          end
        end
        SEQ_ERASE: begin
          seq_q  <= SEQ_IDLE;
          mode_q <= RD_STAT;
          if (cmd != CMD_CONFIRM) begin
            stat_q[ST_ERASE_ERR] <= 1'b1;
            stat_q[ST_PROG_ERR]  <= 1'b1;
          end else if (locked) begin
            stat_q[ST_ERASE_ERR] <= 1'b1;
            stat_q[ST_LOCK_ERR]  <= 1'b1;
          end
        end
        default: begin
          unique case (cmd)
            CMD_RD_ARRAY: mode_q <= RD_ARRAY;
            CMD_RD_ID:    mode_q <= RD_ID;
            CMD_RD_STAT:  mode_q <= RD_STAT;
            CMD_CLR_STAT: begin
              stat_q[ST_ERASE_ERR] <= 1'b0;
              stat_q[ST_PROG_ERR]  <= 1'b0;
              stat_q[ST_LOCK_ERR]  <= 1'b0;
            end
            CMD_ERASE: begin
              seq_q  <= SEQ_ERASE;
              mode_q <= RD_STAT;
            end
            CMD_PROG, CMD_PROG_ALT: begin
              seq_q  <= SEQ_PROG;
              mode_q <= RD_STAT;
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  assign status_w = {{(DATA_W-8){1'b0}}, ~busy, stat_q};

  always_comb begin
    if (busy || mode_q == RD_STAT) rd_val = status_w;
    else if (mode_q == RD_ID) begin
      if (addr_i == '0)                rd_val = MFR_CODE;
      else if (addr_i == ADDR_W'(1))   rd_val = DEV_CODE;
      else                             rd_val = '0;
    end else                           rd_val = arr_rd;
  end

  assign dq_oe_o = ~ce_ni & ~oe_ni & rp_ni & ~pd;
  assign dq_o    = dq_oe_o ? rd_val : '0;

  p_wake_state_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pd) |-> (mode_q == RD_ARRAY && seq_q == SEQ_IDLE && stat_q == '0));

  p_busy_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && dq_oe_o |-> !dq_o[7]);

  p_lock_reject_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && seq_q != SEQ_IDLE && locked |=> !busy);

  p_id_reserved_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy && mode_q == RD_ID && dq_oe_o && addr_i > ADDR_W'(1) |-> dq_o == '0);
endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
  localparam int AW = 8, DW = 16, BW = 5, PC = 24, EC = 48, RPM = 13;
  localparam logic [7:0]  LOCK = 8'h80;
  localparam logic [15:0] MFR = 16'h005A, DEV = 16'h00C3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, rp_n = 1'b1, wp_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic [DW-1:0] dq;
  logic          dq_oe;

  always #4 clk = ~clk;

  flash_cmd_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .BLK_W(BW), .PROG_CYC(PC), .ERASE_CYC(EC),
    .RP_MIN(RPM), .LOCK_MASK(LOCK), .MFR_CODE(MFR), .DEV_CODE(DEV)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .rp_ni(rp_n), .wp_ni(wp_n), .addr_i(addr), .data_i(data),
    .dq_o(dq), .dq_oe_o(dq_oe)
  );

  // behavioural reference state
  int m_mem [256];
  int m_mode, m_seq, m_stat, m_op, m_cnt, m_oa, m_od, m_rpc, m_la, m_ld;
  bit m_pd, m_wrq;
  int checks = 0, fails = 0;
  string cur = "R1";
  logic [DW-1:0] last_dq;

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic model_init();
    foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
    m_mode = 0; m_seq = 0; m_stat = 0; m_op = 0; m_cnt = 0; m_oa = 0; m_od = 0;
    m_rpc = 0; m_la = 0; m_ld = 0; m_pd = 0; m_wrq = 0;
  endtask

  function automatic int exp_val();
    int a = int'(addr);
    if (m_op != 0 || m_mode == 2) return (m_op != 0 ? 0 : 128) | m_stat;
    if (m_mode == 1) return a == 0 ? int'(MFR) : (a == 1 ? int'(DEV) : 0);
    return m_mem[a];
  endfunction

  task automatic model_step();
    bit wr_now = !ce_n && !we_n;
    bit commit = m_wrq && !wr_now && rp_n && !m_pd;
    bit enter  = !rp_n && !m_pd && (m_rpc == RPM - 1);
    bit wake   = rp_n && m_pd;
    bit busy   = (m_op != 0);
    if (busy) begin
      if (enter || m_cnt == 0) begin
        for (int i = 0; i < 256; i++) begin
          if (m_op == 1 && i == m_oa) m_mem[i] = enter ? 0 : (m_mem[i] & m_od);
          if (m_op == 2 && (i >> BW) == (m_oa >> BW)) m_mem[i] = enter ? 0 : 16'hFFFF;
        end
        m_op = 0;
      end else m_cnt--;
    end
    if (wake) begin
      m_mode = 0; m_seq = 0; m_stat = 0;
    end else if (commit && !busy) begin
      int c = m_ld & 255;
      bit lk = !wp_n && LOCK[m_la >> BW];
      if (m_seq == 2) begin
        m_seq = 0; m_mode = 2;
        if (lk) m_stat |= 8'h12;
        else begin m_op = 1; m_cnt = PC - 1; m_oa = m_la; m_od = m_ld; end
      end else if (m_seq == 1) begin
        m_seq = 0; m_mode = 2;
        if (c != 8'hD0) m_stat |= 8'h30;
        else if (lk) m_stat |= 8'h22;
        else begin m_op = 2; m_cnt = EC - 1; m_oa = m_la; m_od = m_ld; end
      end else begin
        case (c)
          8'hFF: m_mode = 0;
          8'h90: m_mode = 1;
          8'h70: m_mode = 2;
          8'h50: m_stat &= ~8'h32;
          8'h20: begin m_seq = 1; m_mode = 2; end
          8'h40, 8'h10: begin m_seq = 2; m_mode = 2; end
          default: ;
        endcase
      end
    end
    if (rp_n) m_rpc = 0; else if (m_rpc != RPM) m_rpc++;
    m_pd = enter || (m_pd && !rp_n);
    m_wrq = wr_now;
    if (wr_now) begin m_la = int'(addr); m_ld = int'(data); end
  endtask

  // one bus cycle: drive, compare every output against the model, then advance it
  task automatic cyc(input logic c, input logic o, input logic w, input logic r,
                     input logic [AW-1:0] a, input logic [DW-1:0] d);
    bit eoe;
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; rp_n = r; addr = a; data = d;
    #3;
    eoe = !ce_n && !oe_n && rp_n && !m_pd;
    chk({cur, " R2 oe"}, int'(dq_oe), int'(eoe));
    chk({cur, " dq"}, int'(dq), eoe ? exp_val() : 0);
    last_dq = dq;
    @(posedge clk);
    model_step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 1, 1, '0, '0);
  endtask

  // WE-controlled write; bus changes after the rising edge must be ignored (R3)
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cyc(0, 1, 0, 1, a, d);
    cyc(0, 1, 1, 1, ~a, ~d);
    cyc(1, 1, 1, 1, '0, '0);
  endtask

  // CE-controlled write (R3)
  task automatic wr_ce(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cyc(0, 1, 0, 1, a, d);
    cyc(1, 1, 0, 1, ~a, ~d);
    cyc(1, 1, 1, 1, '0, '0);
  endtask

  task automatic rd_exp(input logic [AW-1:0] a, input int exp, input string r);
    cyc(0, 0, 1, 1, a, '0);
    chk(r, int'(last_dq), exp);
  endtask

  task automatic rp_low(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 1, 0, '0, '0);
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    model_init();
    #20;
    chk("R1 reset hiz", int'(dq_oe), 0);
    @(negedge clk); rst_n = 1'b1;

    cur = "R1";
    rd_exp(8'd5, 16'hFFFF, "R1 erased array");
    rd_exp(8'd255, 16'hFFFF, "R1 erased array");
    wr(8'd9, 16'h0070);
    rd_exp(8'd0, 16'h0080, "R1 status 80");

    cur = "R2";
    cyc(0, 1, 1, 1, 8'd0, '0); chk("R2 oe high", int'(dq_oe), 0);
    cyc(1, 0, 1, 1, 8'd0, '0); chk("R2 ce high", int'(dq_oe), 0);

    cur = "R4";
    wr(8'd7, 16'h00FF);
    wr(8'd3, 16'h1234);
    rd_exp(8'd3, 16'hFFFF, "R4 cmd no array write");
    wr(8'd200, 16'hAB90);
    cur = "R5";
    rd_exp(8'd0, MFR, "R5 mfr");
    rd_exp(8'd1, DEV, "R5 dev");
    rd_exp(8'd2, 0, "R5 reserved");
    rd_exp(8'd200, 0, "R5 reserved high");

    cur = "R6";
    wr(8'd0, 16'h0040);
    wr(8'd10, 16'hF0F3);
    rd_exp(8'd10, 16'h0000, "R8 busy status");
    wr(8'd0, 16'h00FF);
    rd_exp(8'd10, 16'h0000, "R8 cmd ignored while busy");
    idle(PC);
    rd_exp(8'd10, 16'h0080, "R8 ready status mode");
    wr(8'd0, 16'h00FF);
    rd_exp(8'd10, 16'hF0F3, "R6 programmed");
    wr(8'd0, 16'h0010);
    wr(8'd10, 16'h0FFF);
    idle(PC + 2);
    wr(8'd0, 16'h00FF);
    rd_exp(8'd10, 16'h00F3, "R6 AND program");

    cur = "R3";
    wr_ce(8'd44, 16'h0090);
    rd_exp(8'd1, DEV, "R3 ce write");

    cur = "R7";
    wr(8'd0, 16'h0040); wr(8'd33, 16'h1111); idle(PC + 1);
    wr(8'd0, 16'h0020);
    wr(8'd40, 16'h00D0);
    idle(EC + 2);
    wr(8'd0, 16'h00FF);
    rd_exp(8'd33, 16'hFFFF, "R7 block erased");
    rd_exp(8'd32, 16'hFFFF, "R7 block erased");
    rd_exp(8'd10, 16'h00F3, "R7 other block kept");
    wr(8'd0, 16'h0020);
    wr(8'd0, 16'h00FF);
    rd_exp(8'd0, 16'h00B0, "R7 bad confirm");

    cur = "R10";
    wr(8'd0, 16'h0050);
    rd_exp(8'd0, 16'h0080, "R10 cleared, status mode");

    cur = "R9";
    wp_n = 1'b0;
    wr(8'd0, 16'h0040);
    wr(8'd250, 16'h0000);
    rd_exp(8'd0, 16'h0092, "R9 locked program");
    wr(8'd0, 16'h0050);
    wr(8'd0, 16'h0020);
    wr(8'd230, 16'h00D0);
    rd_exp(8'd0, 16'h00A2, "R9 locked erase");
    wr(8'd0, 16'h0050);
    wr(8'd0, 16'h00FF);
    rd_exp(8'd250, 16'hFFFF, "R9 array unchanged");
    wp_n = 1'b1;

    cur = "R11";
    wr(8'd0, 16'h0040);
    wr(8'd12, 16'h00AA);
    idle(PC + 2);
    wr(8'd0, 16'h00FF);
    rd_exp(8'd12, 16'h00AA, "R11 standby completes");

    cur = "R12";
    wr(8'd0, 16'h0090);
    rp_low(RPM - 1);
    rd_exp(8'd0, MFR, "R12 short pulse ignored");
    rp_low(RPM + 3);
    chk("R12 pd hiz", int'(dq_oe), 0);
    idle(1);
    rd_exp(8'd20, 16'hFFFF, "R12 wake array mode");
    wr(8'd0, 16'h0040);
    rp_low(RPM + 1); idle(1);
    wr(8'd14, 16'h0000);
    rd_exp(8'd14, 16'hFFFF, "R12 setup dropped");
    wr(8'd0, 16'h0070);
    rd_exp(8'd0, 16'h0080, "R12 status 80");

    cur = "R13";
    wr(8'd0, 16'h0040);
    wr(8'd16, 16'h5555);
    rp_low(RPM + 2); idle(1);
    rd_exp(8'd16, 16'h0000, "R13 program abort");
    rd_exp(8'd17, 16'hFFFF, "R13 neighbour intact");
    wr(8'd0, 16'h0020);
    wr(8'd70, 16'h00D0);
    rp_low(RPM + 2); idle(1);
    rd_exp(8'd64, 16'h0000, "R13 erase abort");
    rd_exp(8'd95, 16'h0000, "R13 erase abort");
    rd_exp(8'd96, 16'hFFFF, "R13 next block intact");
    wr(8'd0, 16'h0070);
    rd_exp(8'd0, 16'h0080, "R13 ready after wake");

    idle(4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule